// File: doc/BRIEF.md
# Interrupt Redirection Unit

This block routes up to 24 interrupt input pins to processor-bound delivery messages. Each pin owns a 64-bit redirection entry that sets the vector, delivery mode, destination and destination mode of its message. The entry also decides whether the pin is active high or active low, edge or level sensitive, and masked or open. A level-sensitive pin that has been delivered carries a remote-acknowledge flag. While that flag is set, the pin is not sent again. An end-of-interrupt vector arriving on a side input clears the flag.

Software reaches every internal register through two 32-bit locations. A select register at byte offset 0x00 picks the internal register. A data window at offset 0x10 reads or writes the picked register. Each 64-bit entry is split into two selectable 32-bit halves. Serviced entries leave the block as one message at a time on a valid/ready output. When several pins wait, the lowest pin number goes first.

Top module: `redir_unit`

## Requirements
- R1: After reset the select register and the ID read 0, and every entry has its mask bit set, so its low half reads 0x0001_0000 and its high half reads 0. No message is valid.
- R2: A write takes effect only when `bus_size` is 4 or 8, and it uses `bus_wdata`. A read of offset 0x00 returns the select register, and a read of offset 0x10 returns the selected internal register. A read of any other offset returns 0. `bus_rdata` is updated on the clock edge that samples `bus_rd`.
- R3: Select 0x01 reads (NPINS-1) in bits 23:16 and the version code 0x11 in bits 7:0. Writes to it change nothing.
- R4: Select 0x00 holds a 4-bit ID in bits 27:24. Select 0x02 reads the same value and ignores writes. Selects 0x03 to 0x0F read 0.
- R5: A select s of 0x10 or more addresses entry (s-0x10)/2. An odd s maps to bits 63:32 and an even s maps to bits 31:0. The low-half fields are: vector 7:0, delivery mode 10:8, logical destination 11, polarity 13, remote flag 14 (read-only), level trigger 15 and mask 16. The only high-half field is destination 63:56. Other bits read 0. Entry indices at or beyond NPINS ignore writes and read 0.
- R6: The effective level of a pin is the input XOR the polarity bit. A rise of the effective level marks the pin pending and requests service if the pin is edge triggered or its remote flag is clear. A fall clears pending.
- R7: Servicing an unmasked entry emits a message. If the entry is level triggered, service also sets its remote flag. A masked entry emits nothing. An edge entry loses its pending mark on service, masked or not.
- R8: An edge-triggered pin gives exactly one message per rise of its effective level, however long the level stays high.
- R9: A level-triggered pin whose remote flag is set is not delivered again while its input stays asserted.
- R10: An end-of-interrupt clears the remote flag of the lowest-numbered entry whose vector matches. If that entry is unmasked and still pending, it is delivered again. A vector with no match changes nothing.
- R11: Writing an entry's low half clears its remote flag. Any write to an entry services it again if it is pending, whatever its remote flag.
- R12: The message and `msg_valid` stay stable while `msg_ready` is low. Among pins waiting for service, the lowest number is served first. A message becomes valid on the second clock edge after the input change that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset (0x00 select, 0x10 window) |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NPINS | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dest_logical | output | 1 | Destination is logical |
| msg_level | output | 1 | Message comes from a level-triggered entry |
| msg_dest | output | 8 | Destination field |

## Verification
A remote flag stuck at 1 shows up as a missing redelivery after the matching end-of-interrupt. A stuck-clear flag shows up as a repeated message while a level pin stays asserted. Either is visible in the message stream within three cycles, and also in bit 14 of the entry's low half on the next read. A pending mark that is wrong appears as a lost or doubled message after an entry write or an end-of-interrupt. A broken arbiter appears as messages leaving out of pin order while the output is stalled.

// File: rtl/redir_pkg.sv
package redir_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       remote;
    logic       pol;
    logic       dest_logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } redir_entry_t;

  // bit positions of the low half, shared by decode and read-back
  localparam int LO_VEC_LSB  = 0;
  localparam int LO_DM_LSB   = 8;
  localparam int LO_DL_BIT   = 11;
  localparam int LO_POL_BIT  = 13;
  localparam int LO_RIRR_BIT = 14;
  localparam int LO_LVL_BIT  = 15;
  localparam int LO_MSK_BIT  = 16;
  localparam int HI_DST_LSB  = 24;

  localparam redir_entry_t ENTRY_RESET = '{
    dest: 8'd0, mask: 1'b1, level: 1'b0, remote: 1'b0, pol: 1'b0,
    dest_logical: 1'b0, dmode: 3'd0, vector: 8'd0
  };

  function automatic logic [31:0] entry_low_word(input redir_entry_t e);
    logic [31:0] w;
    w = '0;
    w[LO_VEC_LSB +: 8] = e.vector;
    w[LO_DM_LSB +: 3]  = e.dmode;
    w[LO_DL_BIT]       = e.dest_logical;
    w[LO_POL_BIT]      = e.pol;
    w[LO_RIRR_BIT]     = e.remote;
    w[LO_LVL_BIT]      = e.level;
    w[LO_MSK_BIT]      = e.mask;
    return w;
  endfunction

  function automatic logic [31:0] entry_high_word(input redir_entry_t e);
    logic [31:0] w;
    w = '0;
    w[HI_DST_LSB +: 8] = e.dest;
    return w;
  endfunction

endpackage

// File: rtl/redir_lowest.sv
// Lowest-index-first one-hot picker.
module redir_lowest #(
  parameter int N  = 24,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  always_comb begin
    any    = 1'b0;
    onehot = '0;
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any       = 1'b1;
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IW'(i);
      end
    end
  end
endmodule

// File: rtl/redir_pin.sv
// State of one input pin: its entry, effective-level history,
// pending mark and service request.
module redir_pin
  import redir_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         irq_raw,
  input  logic         wr_low,
  input  logic         wr_high,
  input  redir_entry_t wr_val,
  input  logic         grant,
  input  logic         eoi_hit,
  output redir_entry_t entry,
  output logic         svc_req
);
  logic eff, eff_q, rise, fall, pending;

  assign eff  = irq_raw ^ entry.pol;
  assign rise = eff & ~eff_q;
  assign fall = ~eff & eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      entry   <= ENTRY_RESET;
      pending <= 1'b0;
      svc_req <= 1'b0;
      eff_q   <= 1'b0;
    end else begin
      eff_q <= eff;
      // service granted by the output arbiter
      if (grant) begin
        svc_req <= 1'b0;
        if (!entry.mask && entry.level) entry.remote <= 1'b1;
        if (!entry.level) pending <= 1'b0;
      end
      // input level events
      if (fall) pending <= 1'b0;
      if (rise) begin
        pending <= 1'b1;
        if (!entry.level || !entry.remote) svc_req <= 1'b1;
      end
      // end of interrupt
      if (eoi_hit) begin
        entry.remote <= 1'b0;
        if (!entry.mask && pending) svc_req <= 1'b1;
      end
      // register writes
      if (wr_low) begin
        entry.vector       <= wr_val.vector;
        entry.dmode        <= wr_val.dmode;
        entry.dest_logical <= wr_val.dest_logical;
        entry.pol          <= wr_val.pol;
        entry.level        <= wr_val.level;
        entry.mask         <= wr_val.mask;
        entry.remote       <= 1'b0;
      end
      if (wr_high) entry.dest <= wr_val.dest;
      if ((wr_low || wr_high) && pending) svc_req <= 1'b1;
    end
  end
endmodule

// File: rtl/redir_regport.sv
// Select/window register access: decode, ID register, read mux.
module redir_regport
  import redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         IW      = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  redir_entry_t      ent [NPINS],
  output logic [NPINS-1:0]  wr_low,
  output logic [NPINS-1:0]  wr_high,
  output redir_entry_t      wr_val
);
  localparam logic [ADDR_W-1:0] OFS_SEL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_WIN = ADDR_W'(8'h10);
  localparam logic [31:0] SEL_ID  = 32'h00;
  localparam logic [31:0] SEL_VER = 32'h01;
  localparam logic [31:0] SEL_ARB = 32'h02;
  localparam logic [31:0] SEL_TBL = 32'h10;

  logic [31:0] sel_q;
  logic [3:0]  id_q;
  logic        size_ok, sel_wr, win_wr;
  logic [31:0] ent_off;
  logic [30:0] ent_idx;
  logic        is_tbl, idx_ok, hi_half;
  logic [31:0] ind_val;
  logic        unused_wbits;

  assign size_ok = (bus_size == 4'd4) || (bus_size == 4'd8);
  assign sel_wr  = bus_wr && size_ok && (bus_addr == OFS_SEL);
  assign win_wr  = bus_wr && size_ok && (bus_addr == OFS_WIN);

  assign ent_off = sel_q - SEL_TBL;
  assign ent_idx = ent_off[31:1];
  assign hi_half = ent_off[0];
  assign is_tbl  = (sel_q >= SEL_TBL);
  assign idx_ok  = is_tbl && (ent_idx < 31'(NPINS));

  always_comb begin
    wr_val              = ENTRY_RESET;
    wr_val.vector       = bus_wdata[LO_VEC_LSB +: 8];
    wr_val.dmode        = bus_wdata[LO_DM_LSB +: 3];
    wr_val.dest_logical = bus_wdata[LO_DL_BIT];
    wr_val.pol          = bus_wdata[LO_POL_BIT];
    wr_val.level        = bus_wdata[LO_LVL_BIT];
    wr_val.mask         = bus_wdata[LO_MSK_BIT];
    wr_val.remote       = 1'b0;
    wr_val.dest         = bus_wdata[HI_DST_LSB +: 8];
  end
  assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[LO_RIRR_BIT], bus_wdata[12]};

  for (genvar i = 0; i < NPINS; i++) begin : g_dec
    assign wr_low[i]  = win_wr && idx_ok && (ent_idx == 31'(i)) && !hi_half;
    assign wr_high[i] = win_wr && idx_ok && (ent_idx == 31'(i)) &&  hi_half;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata;
      if (win_wr && sel_q == SEL_ID) id_q <= bus_wdata[27:24];
    end
  end

  always_comb begin
    ind_val = '0;
    if (sel_q == SEL_VER) begin
      ind_val = {8'd0, 8'(NPINS - 1), 8'd0, VERSION};
    end else if (sel_q == SEL_ID || sel_q == SEL_ARB) begin
      ind_val = {4'd0, id_q, 24'd0};
    end else if (idx_ok) begin
      ind_val = hi_half ? entry_high_word(ent[ent_idx[IW-1:0]])
                        : entry_low_word(ent[ent_idx[IW-1:0]]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == OFS_SEL)      bus_rdata <= sel_q;
      else if (bus_addr == OFS_WIN) bus_rdata <= ind_val;
      else                          bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/redir_unit.sv
module redir_unit
  import redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  irq_in,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_dmode,
  output logic              msg_dest_logical,
  output logic              msg_level,
  output logic [7:0]        msg_dest
);
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;

  redir_entry_t       ent [NPINS];
  redir_entry_t       wr_val;
  redir_entry_t       gnt_ent;
  logic [NPINS-1:0]   wr_low, wr_high, svc, gnt_req, gnt_oh;
  logic [NPINS-1:0]   eoi_match, eoi_oh;
  logic [NPINS-1:0]   remote_bits, level_bits;
  logic [NPINS*8-1:0] vec_flat;
  logic [IW-1:0]      gnt_idx, unused_eoi_idx;
  logic               gnt_any, unused_eoi_any, out_free;

  redir_regport #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .VERSION(VERSION), .IW(IW)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ent(ent), .wr_low(wr_low), .wr_high(wr_high),
    .wr_val(wr_val)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    redir_pin u_pin (
      .clk(clk), .rst(rst), .irq_raw(irq_in[i]),
      .wr_low(wr_low[i]), .wr_high(wr_high[i]), .wr_val(wr_val),
      .grant(gnt_oh[i]), .eoi_hit(eoi_oh[i]),
      .entry(ent[i]), .svc_req(svc[i])
    );
    assign eoi_match[i]       = eoi_valid && (ent[i].vector == eoi_vector);
    assign remote_bits[i]     = ent[i].remote;
    assign level_bits[i]      = ent[i].level;
    assign vec_flat[i*8 +: 8] = ent[i].vector;
  end

  // output slot is free when empty or being drained this cycle
  assign out_free = !msg_valid || msg_ready;
  assign gnt_req  = out_free ? svc : '0;

  redir_lowest #(.N(NPINS), .IW(IW)) u_gnt_pick (
    .req(gnt_req), .any(gnt_any), .onehot(gnt_oh), .idx(gnt_idx)
  );

  redir_lowest #(.N(NPINS), .IW(IW)) u_eoi_pick (
    .req(eoi_match), .any(unused_eoi_any), .onehot(eoi_oh), .idx(unused_eoi_idx)
  );

  assign gnt_ent = ent[gnt_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid        <= 1'b0;
      msg_vector       <= '0;
      msg_dmode        <= '0;
      msg_dest_logical <= 1'b0;
      msg_level        <= 1'b0;
      msg_dest         <= '0;
    end else begin
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (gnt_any && !gnt_ent.mask) begin
        msg_valid        <= 1'b1;
        msg_vector       <= gnt_ent.vector;
        msg_dmode        <= gnt_ent.dmode;
        msg_dest_logical <= gnt_ent.dest_logical;
        msg_level        <= gnt_ent.level;
        msg_dest         <= gnt_ent.dest;
      end
    end
  end
endmodule

// File: rtl/redir_unit_chk.sv
module redir_unit_chk #(
  parameter int NPINS = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [7:0]         msg_vector,
  input logic [7:0]         msg_dest,
  input logic               msg_level,
  input logic [NPINS-1:0]   remote_bits,
  input logic [NPINS-1:0]   level_bits,
  input logic [NPINS-1:0]   gnt_oh,
  input logic [NPINS*8-1:0] vec_flat
);
  // R12: a stalled message holds still
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
                                && $stable(msg_dest) && $stable(msg_level));

  // R12: at most one pin serviced per cycle
  a_r12_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_oh));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
    // R9: only level-triggered entries ever carry the remote flag
    a_r9_remote_level: assert property (@(posedge clk) disable iff (rst)
      remote_bits[i] |-> level_bits[i]);

    // R7: the remote flag rises together with that entry's message
    a_r7_remote_msg: assert property (@(posedge clk) disable iff (rst)
      $rose(remote_bits[i]) |-> msg_valid && msg_level
                                && (msg_vector == vec_flat[i*8 +: 8]));
  end
endmodule

bind redir_unit redir_unit_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_level(msg_level),
  .remote_bits(remote_bits), .level_bits(level_bits), .gnt_oh(gnt_oh),
  .vec_flat(vec_flat)
);

// File: tb/redir_unit_test.sv
`timescale 1ns/1ps
module redir_unit_test;
  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [3:0]    bus_size = 4'd4;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] irq_in = '0;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;
  logic          msg_valid, msg_ready = 1'b1;
  logic [7:0]    msg_vector, msg_dest;
  logic [2:0]    msg_dmode;
  logic          msg_dest_logical, msg_level;

  always #2.5 clk = ~clk;

  redir_unit #(.NPINS(NP)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_dest_logical(msg_dest_logical), .msg_level(msg_level),
    .msg_dest(msg_dest)
  );

  int tests = 0, fails = 0;
  logic [7:0] lg_vec  [0:255];
  logic [7:0] lg_dest [0:255];
  logic [3:0] lg_mode [0:255];
  logic       lg_lvl  [0:255];
  int lg_n = 0;

  // message log: a handshake happens at the next rising edge
  always @(negedge clk) begin
    #1;
    if (!rst && msg_valid && msg_ready) begin
      if (lg_n < 256) begin
        lg_vec[lg_n]  = msg_vector;
        lg_dest[lg_n] = msg_dest;
        lg_mode[lg_n] = {msg_dest_logical, msg_dmode};
        lg_lvl[lg_n]  = msg_level;
      end
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [31:0] mk_low(input logic [7:0] vec, input logic [2:0] dm,
      input logic dl, input logic pol, input logic lvl, input logic msk);
    return {15'd0, msk, lvl, 1'b0, pol, 1'b0, dl, dm, vec};
  endfunction

  function automatic logic [31:0] tbl_sel(input int idx, input int hi);
    return 32'h10 + 32'(2 * idx + hi);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 4'd4;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [31:0] sel, input logic [31:0] d);
    wr(8'h00, sel, 4'd4);
    wr(8'h10, d, 4'd4);
  endtask

  task automatic reg_rd(input logic [31:0] sel, output logic [31:0] d);
    wr(8'h00, sel, 4'd4);
    rd(8'h10, d);
  endtask

  task automatic set_entry(input int idx, input logic [31:0] lo, input logic [31:0] hi);
    reg_wr(tbl_sel(idx, 1), hi);
    reg_wr(tbl_sel(idx, 0), lo);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_in = '0; msg_ready = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  logic [31:0] rv;
  int n0;
  logic [31:0] sh_lo [NP];
  logic [31:0] sh_hi [NP];

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // ---- R1 reset state
    chk("R1 msg_valid", {31'd0, msg_valid}, 32'd0);
    rd(8'h00, rv);            chk("R1 select", rv, 32'd0);
    reg_rd(32'h00, rv);       chk("R1 id", rv, 32'd0);
    reg_rd(tbl_sel(0, 0), rv);  chk("R1 entry0 low", rv, 32'h0001_0000);
    reg_rd(tbl_sel(NP-1, 0), rv); chk("R1 last entry low", rv, 32'h0001_0000);
    reg_rd(tbl_sel(NP-1, 1), rv); chk("R1 last entry high", rv, 32'd0);

    // ---- R3 version
    reg_rd(32'h01, rv);       chk("R3 version", rv, 32'h0017_0011);
    wr(8'h10, 32'hFFFF_FFFF, 4'd4);
    rd(8'h10, rv);            chk("R3 version write ignored", rv, 32'h0017_0011);

    // ---- R4 ID and arbitration
    reg_wr(32'h00, 32'hA500_0000);
    rd(8'h10, rv);            chk("R4 id", rv, 32'h0500_0000);
    reg_rd(32'h02, rv);       chk("R4 arb mirrors id", rv, 32'h0500_0000);
    wr(8'h10, 32'h0F00_0000, 4'd4);
    reg_rd(32'h00, rv);       chk("R4 arb write ignored", rv, 32'h0500_0000);
    reg_rd(32'h03, rv);       chk("R4 unused select", rv, 32'd0);

    // ---- R2 access size and offsets
    wr(8'h00, 32'h12, 4'd2);
    rd(8'h00, rv);            chk("R2 size 2 dropped", rv, 32'h03);
    wr(8'h00, 32'h13, 4'd8);
    rd(8'h00, rv);            chk("R2 size 8 accepted", rv, 32'h13);
    rd(8'h20, rv);            chk("R2 other offset", rv, 32'd0);
    rd(8'h04, rv);            chk("R2 offset 4", rv, 32'd0);

    // ---- R5 out-of-range index
    reg_wr(tbl_sel(NP, 0), 32'hFFFF_FFFF);
    rd(8'h10, rv);            chk("R5 beyond pins reads 0", rv, 32'd0);
    reg_rd(tbl_sel(0, 0), rv); chk("R5 entry0 untouched", rv, 32'h0001_0000);

    // ---- R8 edge pin 3
    set_entry(3, mk_low(8'h33, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0), 32'h5A00_0000);
    reg_rd(tbl_sel(3, 0), rv); chk("R5 low layout", rv, 32'h0000_0933);
    reg_rd(tbl_sel(3, 1), rv); chk("R5 high layout", rv, 32'h5A00_0000);
    n0 = lg_n;
    @(negedge clk) irq_in[3] = 1'b1;
    idle(3);
    chk("R8 one message on rise", 32'(lg_n - n0), 32'd1);
    chk("R7 message vector", {24'd0, lg_vec[n0]}, 32'h33);
    chk("R7 message dest", {24'd0, lg_dest[n0]}, 32'h5A);
    chk("R7 message mode", {28'd0, lg_mode[n0]}, 32'h9);
    chk("R7 message edge", {31'd0, lg_lvl[n0]}, 32'd0);
    idle(5);
    chk("R8 steady high no repeat", 32'(lg_n - n0), 32'd1);
    @(negedge clk) irq_in[3] = 1'b0;
    idle(2);
    @(negedge clk) irq_in[3] = 1'b1;
    idle(3);
    chk("R8 second rise", 32'(lg_n - n0), 32'd2);

    // ---- R9 / R10 level pin 5
    set_entry(5, mk_low(8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0), 32'h0100_0000);
    n0 = lg_n;
    @(negedge clk) irq_in[5] = 1'b1;
    idle(3);
    chk("R7 level message", 32'(lg_n - n0), 32'd1);
    chk("R7 level flag", {31'd0, lg_lvl[n0]}, 32'd1);
    reg_rd(tbl_sel(5, 0), rv); chk("R7 remote set", rv, 32'h0000_C055);
    idle(5);
    chk("R9 no redelivery while remote", 32'(lg_n - n0), 32'd1);
    pulse_eoi(8'h55);
    idle(3);
    chk("R10 eoi redelivers pending", 32'(lg_n - n0), 32'd2);
    reg_rd(tbl_sel(5, 0), rv); chk("R10 remote set again", rv, 32'h0000_C055);
    pulse_eoi(8'h99);
    idle(3);
    reg_rd(tbl_sel(5, 0), rv); chk("R10 unmatched eoi ignored", rv, 32'h0000_C055);
    chk("R10 unmatched eoi no message", 32'(lg_n - n0), 32'd2);
    @(negedge clk) irq_in[5] = 1'b0;
    pulse_eoi(8'h55);
    idle(3);
    reg_rd(tbl_sel(5, 0), rv); chk("R10 eoi clears remote", rv, 32'h0000_8055);
    chk("R10 no delivery when idle", 32'(lg_n - n0), 32'd2);

    // ---- R11 masked level pin 6, re-service on write
    set_entry(6, mk_low(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1), 32'd0);
    n0 = lg_n;
    @(negedge clk) irq_in[6] = 1'b1;
    idle(3);
    chk("R7 masked no message", 32'(lg_n - n0), 32'd0);
    reg_rd(tbl_sel(6, 0), rv); chk("R7 masked no remote", rv, 32'h0001_8066);
    reg_wr(tbl_sel(6, 0), mk_low(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    idle(2);
    chk("R11 unmask reservices", 32'(lg_n - n0), 32'd1);
    reg_wr(tbl_sel(6, 1), 32'h0300_0000);
    idle(2);
    chk("R11 high write reservices", 32'(lg_n - n0), 32'd2);
    chk("R11 new dest", {24'd0, lg_dest[n0 + 1]}, 32'h03);
    reg_wr(tbl_sel(6, 0), mk_low(8'h66, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
    idle(2);
    reg_rd(tbl_sel(6, 0), rv); chk("R11 low write clears remote", rv, 32'h0001_8066);

    // ---- R6 active-low pin 7
    n0 = lg_n;
    set_entry(7, mk_low(8'h70, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0), 32'd0);
    idle(3);
    chk("R6 inverted idle input fires", 32'(lg_n - n0), 32'd1);
    @(negedge clk) irq_in[7] = 1'b1;
    idle(3);
    chk("R6 effective fall no message", 32'(lg_n - n0), 32'd1);
    @(negedge clk) irq_in[7] = 1'b0;
    idle(3);
    chk("R6 effective rise", 32'(lg_n - n0), 32'd2);

    // ---- R12 ordering, latency, stall
    set_entry(2, mk_low(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 32'd0);
    set_entry(9, mk_low(8'h29, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 32'd0);
    n0 = lg_n;
    @(negedge clk) msg_ready = 1'b0;
    @(negedge clk) begin irq_in[2] = 1'b1; irq_in[9] = 1'b1; end
    @(negedge clk);
    chk("R12 not valid after one edge", {31'd0, msg_valid}, 32'd0);
    @(negedge clk);
    chk("R12 valid after two edges", {31'd0, msg_valid}, 32'd1);
    chk("R12 lowest pin first", {24'd0, msg_vector}, 32'h22);
    idle(2);
    chk("R12 held while stalled", {23'd0, msg_valid, msg_vector}, 32'h122);
    msg_ready = 1'b1;
    idle(4);
    chk("R12 two messages", 32'(lg_n - n0), 32'd2);
    chk("R12 order first", {24'd0, lg_vec[n0]}, 32'h22);
    chk("R12 order second", {24'd0, lg_vec[n0 + 1]}, 32'h29);

    // ---- R10 duplicate vector, lowest entry matches
    set_entry(10, mk_low(8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0), 32'd0);
    set_entry(11, mk_low(8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0), 32'd0);
    n0 = lg_n;
    @(negedge clk) begin irq_in[10] = 1'b1; irq_in[11] = 1'b1; end
    idle(4);
    chk("R10 both delivered", 32'(lg_n - n0), 32'd2);
    @(negedge clk) irq_in[10] = 1'b0;
    pulse_eoi(8'h77);
    idle(3);
    reg_rd(tbl_sel(10, 0), rv); chk("R10 lowest match cleared", rv, 32'h0000_8077);
    reg_rd(tbl_sel(11, 0), rv); chk("R10 higher match kept", rv, 32'h0000_C077);

    // ---- R5 random table writes against a shadow model
    do_reset();
    for (int i = 0; i < NP; i++) begin
      sh_lo[i] = 32'h0001_0000;
      sh_hi[i] = 32'd0;
    end
    for (int k = 0; k < 40; k++) begin
      int idx;
      int hi;
      logic [31:0] d;
      idx = int'($urandom % NP);
      hi  = int'($urandom % 2);
      d   = $urandom;
      if (hi == 0) begin
        d = d | 32'h0001_0000;            // keep masked: no delivery
        sh_lo[idx] = d & 32'h0001_AFFF;
      end else begin
        sh_hi[idx] = d & 32'hFF00_0000;
      end
      reg_wr(tbl_sel(idx, hi), d);
      rd(8'h10, rv);
      chk("R5 random readback", rv, (hi == 0) ? sh_lo[idx] : sh_hi[idx]);
    end
    for (int i = 0; i < NP; i++) begin
      reg_rd(tbl_sel(i, 0), rv); chk("R5 sweep low", rv, sh_lo[i]);
      reg_rd(tbl_sel(i, 1), rv); chk("R5 sweep high", rv, sh_hi[i]);
    end
    chk("R7 masked random no message", {31'd0, msg_valid}, 32'd0);

    finish_run();
  end
endmodule